// File: doc/BRIEF.md
# SPI Controller Interrupt Status and Mask Unit

This unit produces the interrupt of an SPI controller. It holds a 7-bit status register. Three of its bits latch transfer events: receive overflow, mode fail and transmit underflow. Four of its bits follow FIFO occupancy on every cycle. Two of those four mirror the FIFO full flags. The other two compare the FIFO counts against programmable thresholds.

Software clears latched events by writing ones to the status offset. It enables interrupt sources through a set offset and disables them through a separate clear offset. The mask itself is never written directly. The level interrupt output is registered, and it is high whenever an enabled status bit is set.

Status bit positions are fixed because the surrounding register map decodes them:

| Bit | Meaning | Kind |
|---|---|---|
| 0 | receive overflow | latched |
| 1 | mode fail | latched |
| 2 | transmit FIFO below its threshold | level |
| 3 | transmit FIFO full | level |
| 4 | receive FIFO at or above its threshold | level |
| 5 | receive FIFO full | level |
| 6 | transmit underflow | latched |

Top module: `spi_irq_ctrl`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, `status_o`, `mask_o` and `irq_o` are all zero.
- R2: A pulse on `ev_rx_overflow`, `ev_mode_fail` or `ev_tx_underflow` sets status bit 0, 1 or 6 respectively on the following cycle. That bit then stays set until it is cleared.
- R3: A write to byte offset 0x04 clears every latched status bit (bits 0, 1 and 6) whose data bit is one. Latched bits written as zero are unchanged.
- R4: When an event pulse and a clearing write hit the same latched bit in the same cycle, the bit is set on the following cycle.
- R5: Status bit 5 equals `rx_full` and status bit 3 equals `tx_full`, each as sampled on the previous clock edge.
- R6: Status bit 4 is one when `rx_count >= rx_thresh`, and status bit 2 is one when `tx_count < tx_thresh`, each as sampled on the previous clock edge.
- R7: A write to byte offset 0x08 sets the mask bits whose data bit is one. Data bits above bit 6 are ignored.
- R8: A write to byte offset 0x0C clears the mask bits whose data bit is one.
- R9: `irq_o` is one exactly when the bitwise AND of mask and status was nonzero on the previous cycle.
- R10: A write to any other offset, including the read-only mask offset 0x10, changes neither the status nor the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Byte offset of the write |
| wr_data | input | DATA_W | Write data |
| rx_count | input | CNT_W | Receive FIFO occupancy |
| tx_count | input | CNT_W | Transmit FIFO occupancy |
| rx_thresh | input | CNT_W | Receive threshold |
| tx_thresh | input | CNT_W | Transmit threshold |
| rx_full | input | 1 | Receive FIFO full |
| tx_full | input | 1 | Transmit FIFO full |
| ev_rx_overflow | input | 1 | Receive overflow event pulse |
| ev_mode_fail | input | 1 | Mode fail event pulse |
| ev_tx_underflow | input | 1 | Transmit underflow event pulse |
| status_o | output | 7 | Status register |
| mask_o | output | 7 | Mask register |
| irq_o | output | 1 | Level interrupt |

## Verification
The assertions check four rules on every cycle. A latched bit holds until a clear arrives. An event beats a clear that arrives in the same cycle. A disable write leaves no disabled bit in the mask. The interrupt follows the masked status one cycle late.

The threshold boundaries cannot be checked that way, and neither can the full-flag mirrors, the masking of bits above bit 6, or the lack of any effect from writes to other offsets. The bench's reference model, compared on every clock, shows those through directed scenarios. These include counts equal to and one off from the thresholds, a zero threshold, and writes to unrelated offsets.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  localparam int STAT_W = 7;

  localparam int B_RX_OVF  = 0;
  localparam int B_MODE_F  = 1;
  localparam int B_TX_LOW  = 2;
  localparam int B_TX_FULL = 3;
  localparam int B_RX_HIGH = 4;
  localparam int B_RX_FULL = 5;
  localparam int B_TX_UNF  = 6;

  localparam logic [STAT_W-1:0] STICKY_MSK = 7'b100_0011;
  localparam logic [STAT_W-1:0] LEVEL_MSK  = 7'b011_1100;
  localparam logic [STAT_W-1:0] VALID_MSK  = 7'h7F;

  localparam logic [7:0] OFF_STATUS   = 8'h04;
  localparam logic [7:0] OFF_MASK_SET = 8'h08;
  localparam logic [7:0] OFF_MASK_CLR = 8'h0C;

  // Latched update: a clear drops a bit, and an event in the same cycle wins.
  function automatic logic [STAT_W-1:0] sticky_next(
    input logic [STAT_W-1:0] cur,
    input logic [STAT_W-1:0] clr,
    input logic [STAT_W-1:0] ev);
    return ((cur & ~clr) | ev) & STICKY_MSK;
  endfunction
endpackage

// File: rtl/irq_level_calc.sv
module irq_level_calc
  import spi_irq_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic [CNT_W-1:0]  rx_count,
  input  logic [CNT_W-1:0]  tx_count,
  input  logic [CNT_W-1:0]  rx_thresh,
  input  logic [CNT_W-1:0]  tx_thresh,
  input  logic              rx_full,
  input  logic              tx_full,
  output logic [STAT_W-1:0] lvl_vec
);
  function automatic logic at_or_above(input logic [CNT_W-1:0] c,
                                       input logic [CNT_W-1:0] t);
    return c >= t;
  endfunction

  always_comb begin
    lvl_vec            = '0;
    lvl_vec[B_TX_LOW]  = !at_or_above(tx_count, tx_thresh);
    lvl_vec[B_TX_FULL] = tx_full;
    lvl_vec[B_RX_HIGH] = at_or_above(rx_count, rx_thresh);
    lvl_vec[B_RX_FULL] = rx_full;
  end
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
  import spi_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] ev_vec,
  input  logic [STAT_W-1:0] clr_vec,
  input  logic [STAT_W-1:0] lvl_vec,
  output logic [STAT_W-1:0] status_q
);
  logic [STAT_W-1:0] sticky_d;

  always_comb sticky_d = sticky_next(status_q, clr_vec, ev_vec);

  always_ff @(posedge clk) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= sticky_d | (lvl_vec & LEVEL_MSK);
  end

  for (genvar i = 0; i < STAT_W; i++) begin : g_chk
    if (STICKY_MSK[i]) begin : g_sticky
      // R2
      sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(status_q[i]) && !$past(clr_vec[i])) |-> status_q[i]);
      // R4
      event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ev_vec[i]) |-> status_q[i]);
    end
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
  import spi_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_we,
  input  logic              clr_we,
  input  logic [STAT_W-1:0] wdata,
  output logic [STAT_W-1:0] mask_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)      mask_q <= '0;
    else if (set_we) mask_q <= mask_q | (wdata & VALID_MSK);
    else if (clr_we) mask_q <= mask_q & ~wdata;
  end

  // R8
  mask_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr_we) |-> ((mask_q & $past(wdata)) == '0));
endmodule

// File: rtl/spi_irq_ctrl.sv
module spi_irq_ctrl
  import spi_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [CNT_W-1:0]  rx_count,
  input  logic [CNT_W-1:0]  tx_count,
  input  logic [CNT_W-1:0]  rx_thresh,
  input  logic [CNT_W-1:0]  tx_thresh,
  input  logic              rx_full,
  input  logic              tx_full,
  input  logic              ev_rx_overflow,
  input  logic              ev_mode_fail,
  input  logic              ev_tx_underflow,
  output logic [6:0]        status_o,
  output logic [6:0]        mask_o,
  output logic              irq_o
);
  logic              hit_status, hit_set, hit_clr;
  logic [STAT_W-1:0] wbits, ev_vec, clr_vec, lvl_vec, status_q, mask_q;
  logic              irq_q;

  assign hit_status = wr_en && (wr_addr == ADDR_W'(OFF_STATUS));
  assign hit_set    = wr_en && (wr_addr == ADDR_W'(OFF_MASK_SET));
  assign hit_clr    = wr_en && (wr_addr == ADDR_W'(OFF_MASK_CLR));
  assign wbits      = wr_data[STAT_W-1:0];
  assign clr_vec    = hit_status ? (wbits & STICKY_MSK) : '0;

  always_comb begin
    ev_vec           = '0;
    ev_vec[B_RX_OVF] = ev_rx_overflow;
    ev_vec[B_MODE_F] = ev_mode_fail;
    ev_vec[B_TX_UNF] = ev_tx_underflow;
  end

  irq_level_calc #(.CNT_W(CNT_W)) u_lvl (
    .rx_count(rx_count), .tx_count(tx_count),
    .rx_thresh(rx_thresh), .tx_thresh(tx_thresh),
    .rx_full(rx_full), .tx_full(tx_full), .lvl_vec(lvl_vec));

  irq_status_reg u_stat (
    .clk(clk), .rst_n(rst_n), .ev_vec(ev_vec), .clr_vec(clr_vec),
    .lvl_vec(lvl_vec), .status_q(status_q));

  irq_mask_reg u_mask (
    .clk(clk), .rst_n(rst_n), .set_we(hit_set), .clr_we(hit_clr),
    .wdata(wbits), .mask_q(mask_q));

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(mask_q & status_q & VALID_MSK);
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;
  assign irq_o    = irq_q;

  // R9
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mask_o & status_o) != '0) |-> irq_o);
  // R9
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mask_o & status_o) == '0) |-> !irq_o);
endmodule

// File: tb/test_spi_irq_ctrl.sv
`timescale 1ns/1ps
module test_spi_irq_ctrl;
  localparam int CW = 7;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [7:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [CW-1:0] rx_count = '0, tx_count = '0, rx_thresh = 1, tx_thresh = 1;
  logic rx_full = 0, tx_full = 0, e_ovf = 0, e_mf = 0, e_unf = 0;
  logic [6:0] status_o, mask_o;
  logic irq_o;

  int tests = 0, fails = 0;
  bit done = 0;
  int m_status = 0, m_mask = 0, m_irq = 0;

  always #5 clk = ~clk;

  spi_irq_ctrl i_spi_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rx_count(rx_count), .tx_count(tx_count), .rx_thresh(rx_thresh), .tx_thresh(tx_thresh),
    .rx_full(rx_full), .tx_full(tx_full), .ev_rx_overflow(e_ovf), .ev_mode_fail(e_mf),
    .ev_tx_underflow(e_unf), .status_o(status_o), .mask_o(mask_o), .irq_o(irq_o));

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Advance one clock with the inputs already applied, then compare with the model.
  task automatic tick();
    int lat, lvl, ns, nm, ni;
    lat = m_status & 'h43;
    if (wr_en && wr_addr == 8'h04) lat = lat & ~int'(wr_data[6:0]);
    if (e_ovf) lat |= 1;
    if (e_mf)  lat |= 2;
    if (e_unf) lat |= 'h40;
    lvl = 0;
    if (int'(tx_count) < int'(tx_thresh))   lvl += 4;
    if (tx_full)                            lvl += 8;
    if (int'(rx_count) >= int'(rx_thresh))  lvl += 16;
    if (rx_full)                            lvl += 32;
    ns = lat + lvl;
    nm = m_mask;
    if (wr_en && wr_addr == 8'h08) nm = nm | int'(wr_data[6:0]);
    if (wr_en && wr_addr == 8'h0C) nm = nm & ~int'(wr_data[6:0]);
    ni = ((m_mask & m_status) != 0) ? 1 : 0;
    @(posedge clk);
    #1;
    m_status = ns; m_mask = nm; m_irq = ni;
    @(negedge clk);
    wr_en = 0; e_ovf = 0; e_mf = 0; e_unf = 0;
    chk("R2 latched bits", int'(status_o) & 'h43, m_status & 'h43);
    chk("R5 full mirrors", int'(status_o) & 'h28, m_status & 'h28);
    chk("R6 threshold bits", int'(status_o) & 'h14, m_status & 'h14);
    chk("R7 mask", int'(mask_o), m_mask);
    chk("R9 irq", int'(irq_o), m_irq);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=hang expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs zero while in reset
    chk("R1 status in reset", int'(status_o), 0);
    chk("R1 irq in reset", int'(irq_o), 0);
    rst_n = 1;
    chk("R1 status after release", int'(status_o), 0);
    chk("R1 mask after release", int'(mask_o), 0);
    tick();
    // R2: each event latches
    e_ovf = 1; tick();
    chk("R2 overflow latched", int'(status_o[0]), 1);
    e_mf = 1; tick();
    e_unf = 1; tick();
    repeat (3) tick();
    chk("R2 underflow held", int'(status_o[6]), 1);
    // R3: partial clear
    wr(8'h04, 32'h0000_0041); tick();
    chk("R3 bits 0 and 6 cleared", int'(status_o) & 'h43, 'h02);
    wr(8'h04, 32'hFFFF_FFFF); tick();
    chk("R3 all latched cleared", int'(status_o) & 'h43, 0);
    // R4: event beats clear
    e_mf = 1; wr(8'h04, 32'h2); tick();
    chk("R4 event wins", int'(status_o[1]), 1);
    // R5 / R6: level patterns, thresholds at boundaries
    rx_thresh = 5; rx_count = 4; tx_thresh = 3; tx_count = 3; tick();
    chk("R6 rx below thresh", int'(status_o[4]), 0);
    chk("R6 tx at thresh", int'(status_o[2]), 0);
    rx_count = 5; tx_count = 2; tick();
    chk("R6 rx at thresh", int'(status_o[4]), 1);
    chk("R6 tx below thresh", int'(status_o[2]), 1);
    rx_thresh = 0; rx_count = 0; tx_thresh = 0; tick();
    chk("R6 zero thresholds", int'(status_o) & 'h14, 'h10);
    rx_full = 1; rx_count = 64; tick();
    chk("R5 rx full", int'(status_o[5]), 1);
    tx_full = 1; rx_full = 0; tick();
    chk("R5 tx full", int'(status_o[3]), 1);
    tx_full = 0; rx_thresh = 1; tx_thresh = 1; rx_count = 0; tx_count = 0; tick();
    // R7: enable with upper bits ignored
    wr(8'h08, 32'hFFFF_FF82); tick();
    chk("R7 mask set", int'(mask_o), 'h02);
    tick();
    chk("R9 irq on mode fail", int'(irq_o), 1);
    // R8: disable
    wr(8'h0C, 32'h2); tick();
    chk("R8 mask cleared", int'(mask_o), 0);
    tick();
    chk("R9 irq drops", int'(irq_o), 0);
    // R10: writes elsewhere ignored
    wr(8'h10, 32'h7F); tick();
    chk("R10 mask offset read-only", int'(mask_o), 0);
    wr(8'h14, 32'h7F); tick();
    chk("R10 status untouched", int'(status_o) & 'h43, 'h02);
    // Level-bit interrupt via threshold
    wr(8'h08, 32'h14); tick();
    rx_count = 3; tick();
    tick();
    chk("R9 irq from rx threshold", int'(irq_o), 1);
    for (int k = 0; k < 40; k++) begin
      tx_count = CW'(k % 5); rx_count = CW'((k * 3) % 7);
      rx_thresh = CW'(k % 4); tx_thresh = CW'((k + 1) % 6);
      rx_full = (k % 7) == 0; tx_full = (k % 5) == 1;
      e_ovf = (k % 6) == 2; e_unf = (k % 9) == 4;
      if (k % 4 == 0) wr(8'h04, 32'(k));
      else if (k % 4 == 1) wr(8'h08, 32'(k * 5));
      else if (k % 4 == 2) wr(8'h0C, 32'(k * 3));
      tick();
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule